// File: doc/BRIEF.md
# Comparator Edge-Event Interrupt Controller

This block turns the digital outputs of a set of analog comparators (two by default) into interrupt flags. Each raw comparator bit first passes through a two-flop synchronizer. A per-channel invert bit is applied next, and the block watches the resulting adjusted level for the transition that the channel's event select asks for: none, rising, falling or either. When the selected transition occurs, the channel's flag is set and stays set until software clears it.

Software reaches the block through a flat register port. Writes are synchronous, and reads are combinational from a separate read address. Each channel has a configuration register holding its invert bit, event select and enable. One register holds the peripheral and global enables. The flag register can be read, and it can be written to clear or set flags, so an interrupt can be forced without any comparator activity. A read-only status register shows the adjusted comparator levels. The interrupt request is a registered OR, taken over channels, of flag AND channel enable, and it is further gated by the peripheral and global enables.

Top module: `cmp_irq_ctrl`

## Requirements
- R1: After reset, every flag, channel configuration, peripheral enable, global enable and `irq_o` reads 0.
- R2: The 2-bit event select in configuration bits [2:1] works as follows: 00 sets no flag, 01 sets the flag when the adjusted level goes low to high, 10 sets it when the level goes high to low, and 11 sets it on either change. A raw edge reaches the flag on the third rising clock after the input changes.
- R3: Configuration bit 0 inverts the raw level before edge selection. With bit 0 set and select 01, a raw high-to-low change sets the flag and a raw low-to-high change does not.
- R4: Once set, a flag stays set, regardless of input activity, until a write to the flag register puts a 0 in its bit.
- R5: A write to the flag register with a 1 in bit c sets flag c in the same clock, with no comparator transition needed.
- R6: `irq_o` is 1 only when some channel has both its flag and its enable (configuration bit 3) set, and both the peripheral enable (global bit 0) and the global enable (global bit 1) are 1. It is registered, so it follows these conditions one clock later.
- R7: A qualifying event sets its flag even while the channel enable, the peripheral enable or the global enable is 0.
- R8: The status register holds the adjusted level of channel c in bit c (raw XOR invert). A raw change appears there after two rising clocks.
- R9: A write that toggles a channel's invert bit changes its adjusted level. If the event select matches that change, the write sets the flag on the next clock.
- R10: If a qualifying event and a flag-register write of 0 to the same flag fall in the same clock, the flag ends up set.
- R11: The channels are independent: an event on one channel never changes another channel's flag.
- R12: Register addresses are: channel c configuration at c (bit 3 enable, bits [2:1] select, bit 0 invert), global enables at NCH, flags at NCH+1, status at NCH+2. Configuration and global registers read back the last value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmp_raw_i | input | NCH | Raw asynchronous comparator outputs |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | AW | Register write address |
| wr_data_i | input | DW | Register write data |
| rd_addr_i | input | AW | Register read address |
| rd_data_o | output | DW | Combinational register read data |
| irq_o | output | 1 | Registered interrupt request |

## Verification
On every cycle, the assertions check four things: a set flag stays set unless software writes its register, a flag cannot rise while its select is 00, a hardware event wins over a clearing write in the same cycle, and a request never appears unless the previous cycle had both global enables and an enabled, flagged channel. Other behaviours need whole scenarios, so only the bench shows them. These are the exact three-cycle latency from a raw edge to its flag, the effect of inversion on which raw edge counts, a flag set by a polarity write, channel independence, and the readback values. The random phase compares flags, status and the request every cycle against a reference model in the bench.

// File: rtl/cmp_irq_pkg.sv
package cmp_irq_pkg;

  typedef enum logic [1:0] {
    EV_NONE = 2'b00,
    EV_RISE = 2'b01,
    EV_FALL = 2'b10,
    EV_ANY  = 2'b11
  } ev_sel_e;

  // bit 3 enable, bits 2:1 select, bit 0 invert
  typedef struct packed {
    logic    en;
    ev_sel_e sel;
    logic    inv;
  } ch_cfg_t;

  function automatic logic ev_hit(ev_sel_e sel, logic prev, logic cur);
    unique case (sel)
      EV_RISE: return ~prev & cur;
      EV_FALL: return prev & ~cur;
      EV_ANY:  return prev ^ cur;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/cmp_irq_sync.sv
module cmp_irq_sync #(
  parameter int unsigned NCH    = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NCH-1:0] d_i,
  output logic [NCH-1:0] q_o
);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [STAGES-1:0] sr_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sr_q <= '0;
      else         sr_q <= {sr_q[STAGES-2:0], d_i[c]};
    end
    assign q_o[c] = sr_q[STAGES-1];
  end

endmodule

// File: rtl/cmp_irq_chan.sv
module cmp_irq_chan
  import cmp_irq_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    sync_i,
  input  ch_cfg_t cfg_i,
  input  logic    sw_we_i,
  input  logic    sw_val_i,
  output logic    adj_o,
  output logic    flag_o
);

  logic prev_q, flag_q, hw_evt;

  assign adj_o  = sync_i ^ cfg_i.inv;
  assign hw_evt = ev_hit(cfg_i.sel, prev_q, adj_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      prev_q <= adj_o;
      // hardware event ORed last: set beats a clearing write
      flag_q <= (sw_we_i ? sw_val_i : flag_q) | hw_evt;
    end
  end

  assign flag_o = flag_q;

  a_r4_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !sw_we_i) |=> flag_q);

  a_r2_none_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flag_q && !sw_we_i && cfg_i.sel == EV_NONE) |=> !flag_q);

  a_r10_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hw_evt && sw_we_i) |=> flag_q);

endmodule

// File: rtl/cmp_irq_regs.sv
module cmp_irq_regs
  import cmp_irq_pkg::*;
#(
  parameter int unsigned NCH = 2,
  parameter int unsigned AW  = 3,
  parameter int unsigned DW  = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [AW-1:0]       wr_addr_i,
  input  logic [DW-1:0]       wr_data_i,
  input  logic [AW-1:0]       rd_addr_i,
  input  logic [NCH-1:0]      flags_i,
  input  logic [NCH-1:0]      status_i,
  output ch_cfg_t [NCH-1:0]   cfg_o,
  output logic                pe_o,
  output logic                ge_o,
  output logic                flag_we_o,
  output logic [NCH-1:0]      flag_wval_o,
  output logic [DW-1:0]       rd_data_o
);

  localparam int unsigned CFG_W  = $bits(ch_cfg_t);
  localparam int unsigned A_GLB  = NCH;
  localparam int unsigned A_FLAG = NCH + 1;
  localparam int unsigned A_STAT = NCH + 2;

  ch_cfg_t [NCH-1:0] cfg_q;
  logic              pe_q, ge_q;
  logic              unused_wr_hi;

  assign unused_wr_hi = ^wr_data_i[DW-1:CFG_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
      pe_q  <= 1'b0;
      ge_q  <= 1'b0;
    end else if (wr_en_i) begin
      for (int c = 0; c < NCH; c++) begin
        if (wr_addr_i == AW'(c)) cfg_q[c] <= ch_cfg_t'(wr_data_i[CFG_W-1:0]);
      end
      if (wr_addr_i == AW'(A_GLB)) begin
        pe_q <= wr_data_i[0];
        ge_q <= wr_data_i[1];
      end
    end
  end

  assign cfg_o       = cfg_q;
  assign pe_o        = pe_q;
  assign ge_o        = ge_q;
  assign flag_we_o   = wr_en_i && (wr_addr_i == AW'(A_FLAG));
  assign flag_wval_o = wr_data_i[NCH-1:0];

  always_comb begin
    rd_data_o = '0;
    for (int c = 0; c < NCH; c++) begin
      if (rd_addr_i == AW'(c)) rd_data_o[CFG_W-1:0] = cfg_q[c];
    end
    if (rd_addr_i == AW'(A_GLB))  rd_data_o[1:0]     = {ge_q, pe_q};
    if (rd_addr_i == AW'(A_FLAG)) rd_data_o[NCH-1:0] = flags_i;
    if (rd_addr_i == AW'(A_STAT)) rd_data_o[NCH-1:0] = status_i;
  end

endmodule

// File: rtl/cmp_irq_ctrl.sv
module cmp_irq_ctrl
  import cmp_irq_pkg::*;
#(
  parameter int unsigned NCH    = 2,
  parameter int unsigned STAGES = 2,
  parameter int unsigned AW     = 3,
  parameter int unsigned DW     = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NCH-1:0] cmp_raw_i,
  input  logic           wr_en_i,
  input  logic [AW-1:0]  wr_addr_i,
  input  logic [DW-1:0]  wr_data_i,
  input  logic [AW-1:0]  rd_addr_i,
  output logic [DW-1:0]  rd_data_o,
  output logic           irq_o
);

  logic [NCH-1:0]    sync, adj, flags, en_vec, flag_wval;
  ch_cfg_t [NCH-1:0] cfg;
  logic              pe, ge, flag_we, irq_q;

  cmp_irq_sync #(.NCH(NCH), .STAGES(STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (cmp_raw_i),
    .q_o   (sync)
  );

  cmp_irq_regs #(.NCH(NCH), .AW(AW), .DW(DW)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .rd_addr_i  (rd_addr_i),
    .flags_i    (flags),
    .status_i   (adj),
    .cfg_o      (cfg),
    .pe_o       (pe),
    .ge_o       (ge),
    .flag_we_o  (flag_we),
    .flag_wval_o(flag_wval),
    .rd_data_o  (rd_data_o)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    cmp_irq_chan u_chan (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .sync_i  (sync[c]),
      .cfg_i   (cfg[c]),
      .sw_we_i (flag_we),
      .sw_val_i(flag_wval[c]),
      .adj_o   (adj[c]),
      .flag_o  (flags[c])
    );
    assign en_vec[c] = cfg[c].en;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= (|(flags & en_vec)) & pe & ge;
  end

  assign irq_o = irq_q;

  a_r6_irq_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(pe && ge));

  a_r6_irq_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(|(flags & en_vec)));

endmodule

// File: tb/sim_cmp_irq_ctrl.sv
module sim_cmp_irq_ctrl;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] raw = '0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       irq;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #5 clk = ~clk;

  cmp_irq_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .cmp_raw_i(raw),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .irq_o(irq)
  );

  // reference model
  logic [1:0] m_s1, m_s2, m_prev, m_flag, m_evt, m_adj;
  logic       m_irq;
  logic [3:0] m_cfg [2];
  logic [1:0] m_glb;

  function automatic logic exp_event(input logic [1:0] sel, input logic p, input logic a);
    case (sel)
      2'b01:   return !p && a;
      2'b10:   return p && !a;
      2'b11:   return p != a;
      default: return 1'b0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = '0; m_s2 = '0; m_prev = '0; m_flag = '0; m_irq = 1'b0;
      m_cfg[0] = '0; m_cfg[1] = '0; m_glb = '0;
    end else begin
      m_irq = (|(m_flag & {m_cfg[1][3], m_cfg[0][3]})) & m_glb[0] & m_glb[1];
      for (int c = 0; c < 2; c++) begin
        m_adj[c] = m_s2[c] ^ m_cfg[c][0];
        m_evt[c] = exp_event(m_cfg[c][2:1], m_prev[c], m_adj[c]);
      end
      if (wr_en && wr_addr == 3'd3) m_flag = wr_data[1:0] | m_evt;
      else                          m_flag = m_flag | m_evt;
      m_prev = m_adj;
      if (wr_en) begin
        if (wr_addr == 3'd0) m_cfg[0] = wr_data[3:0];
        if (wr_addr == 3'd1) m_cfg[1] = wr_data[3:0];
        if (wr_addr == 3'd2) m_glb    = wr_data[1:0];
      end
      m_s2 = m_s1;
      m_s1 = raw;
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'h5EED_0042));
    step(3);
    rst_n = 1'b1;
    step(1);

    // R1 reset state
    rd(3'd3, d); chk("R1 flags", d, 8'h00);
    rd(3'd0, d); chk("R1 cfg0", d, 8'h00);
    rd(3'd2, d); chk("R1 glb", d, 8'h00);
    chk("R1 irq", {7'd0, irq}, 8'h00);

    // R2 rise select, R8 status latency
    wr(3'd0, 8'h02);
    rd(3'd0, d); chk("R12 cfg0 readback", d, 8'h02);
    raw = 2'b01;
    step(2);
    rd(3'd4, d); chk("R8 status after two clocks", d, 8'h01);
    rd(3'd3, d); chk("R2 flag not yet", d, 8'h00);
    step(1);
    rd(3'd3, d); chk("R2 rise sets", d, 8'h01);
    wr(3'd3, 8'h00);
    rd(3'd3, d); chk("R4 software clear", d, 8'h00);
    raw = 2'b00; step(3);
    rd(3'd3, d); chk("R2 rise ignores fall", d, 8'h00);

    // fall select
    wr(3'd0, 8'h04);
    raw = 2'b01; step(3);
    rd(3'd3, d); chk("R2 fall ignores rise", d, 8'h00);
    raw = 2'b00; step(3);
    rd(3'd3, d); chk("R2 fall sets", d, 8'h01);
    wr(3'd3, 8'h00);

    // any select
    wr(3'd0, 8'h06);
    raw = 2'b01; step(3);
    rd(3'd3, d); chk("R2 any on rise", d, 8'h01);
    wr(3'd3, 8'h00);
    raw = 2'b00; step(3);
    rd(3'd3, d); chk("R2 any on fall", d, 8'h01);
    wr(3'd3, 8'h00);

    // none select
    wr(3'd0, 8'h00);
    raw = 2'b01; step(3);
    raw = 2'b00; step(3);
    rd(3'd3, d); chk("R2 none never sets", d, 8'h00);

    // R4 sticky across activity
    wr(3'd0, 8'h02);
    raw = 2'b01; step(3);
    raw = 2'b00; step(5);
    raw = 2'b01; step(5);
    rd(3'd3, d); chk("R4 sticky", d, 8'h01);
    raw = 2'b00; step(3);
    wr(3'd3, 8'h00);

    // R9 invert toggle counts as rise (raw 0 -> adjusted 1)
    wr(3'd0, 8'h03);
    step(1);
    rd(3'd3, d); chk("R9 invert write sets", d, 8'h01);
    wr(3'd3, 8'h00);
    rd(3'd4, d); chk("R8 status inverted", d, 8'h01);

    // R3 inverted rise select
    raw = 2'b01; step(3);
    rd(3'd3, d); chk("R3 raw rise ignored", d, 8'h00);
    raw = 2'b00; step(3);
    rd(3'd3, d); chk("R3 raw fall sets", d, 8'h01);
    wr(3'd3, 8'h00);
    wr(3'd0, 8'h02);
    wr(3'd3, 8'h00);

    // R5 software set, R7 latch while masked, R6 gating
    wr(3'd3, 8'h02);
    rd(3'd3, d); chk("R5 software set", d, 8'h02);
    step(4);
    rd(3'd3, d); chk("R7 flag held while masked", d, 8'h02);
    chk("R6 irq masked", {7'd0, irq}, 8'h00);
    wr(3'd1, 8'h08);
    wr(3'd2, 8'h01);
    step(2);
    chk("R6 irq no global", {7'd0, irq}, 8'h00);
    wr(3'd2, 8'h03);
    rd(3'd2, d); chk("R12 glb readback", d, 8'h03);
    chk("R6 irq registered", {7'd0, irq}, 8'h00);
    step(1);
    chk("R6 irq asserted", {7'd0, irq}, 8'h01);
    wr(3'd3, 8'h00);
    step(1);
    chk("R6 irq drops", {7'd0, irq}, 8'h00);

    // R7 hardware event with channel disabled
    wr(3'd2, 8'h00);
    raw = 2'b01; step(3);
    rd(3'd3, d); chk("R7 event while disabled", d, 8'h01);
    chk("R7 irq stays low", {7'd0, irq}, 8'h00);
    wr(3'd3, 8'h00);
    raw = 2'b00; step(3);

    // R11 independence: ch0 rise, ch1 fall+enable
    wr(3'd1, 8'h0C);
    wr(3'd2, 8'h03);
    raw = 2'b10; step(3);
    rd(3'd3, d); chk("R11 ch1 rise ignored", d, 8'h00);
    raw = 2'b01; step(3);
    rd(3'd3, d); chk("R11 both channels", d, 8'h03);
    step(1);
    chk("R6 irq from ch1", {7'd0, irq}, 8'h01);
    wr(3'd3, 8'h00);
    raw = 2'b00; step(3);
    rd(3'd3, d); chk("R11 ch0 ignores fall", d, 8'h00);

    // R10 event and clear in the same clock
    raw = 2'b01; step(2);
    wr(3'd3, 8'h00);
    rd(3'd3, d); chk("R10 set wins over clear", d, 8'h01);
    wr(3'd3, 8'h00);

    // random phase against reference model
    for (int i = 0; i < 3000; i++) begin
      logic [1:0] exp_st;
      exp_st = m_s2 ^ {m_cfg[1][0], m_cfg[0][0]};
      chk("R6 random irq", {7'd0, irq}, {7'd0, m_irq});
      rd(3'd3, d); chk("R2 random flags", d, {6'd0, m_flag});
      rd(3'd4, d); chk("R8 random status", d, {6'd0, exp_st});
      raw = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 5) == 0) begin
        wr_en = 1'b1;
        wr_addr = 3'($urandom_range(0, 4));
        wr_data = 8'($urandom);
      end else begin
        wr_en = 1'b0;
      end
      @(negedge clk);
    end
    wr_en = 1'b0;
    finish_run();
  end

endmodule